// File: doc/BRIEF.md
# RTC shadow register update controller

This block sits between a byte-wide host register port and the running calendar counters of a real-time clock. The host never touches the live counters directly. Time, alarm and mode values are written into buffer registers, and a transfer is started by setting a request bit in the update-control register. A transfer timer then waits for a programmable delay, performs every pending transfer on a single clock edge and clears the request bits in hardware. Software polls the update-control register to see when a transfer has finished.

There are three request kinds. A time write loads the buffer into the counters. A time read copies the live counters into the same buffer, so the host can read a coherent snapshot one byte at a time. An alarm commit moves the alarm buffer and the control byte into the active registers, which feed a downstream comparator and a formatter. A build option keeps the alarm request bit set after its transfer, until software writes it back to zero. The calendar counters are advanced by a one-cycle seconds tick supplied from outside.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: After reset the live time is 00:00:00, weekday code 0x01, day 1, month 1, year 0. The time buffer, alarm buffer, active alarm and mode output are zero, and the update-control register reads 0x00, which selects the long delay.
- R2: Host writes to time-buffer bytes (address 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 weekday, 0x04 day, 0x05 month, 0x06 year, all binary) leave the live time unchanged until a time-write request (update-control 0x11, bit 0) completes. After that the live time equals the buffer.
- R3: A request bit stays set through the delay and clears on the commit edge. That edge is exactly D+1 clock edges after the edge that wrote the request, where D is SHORT_US*CYC_PER_US when update-control bit 4 is 1 and LONG_US*CYC_PER_US when it is 0.
- R4: A time-read request (bit 1) copies the live counters into the time buffer at the commit edge. Between read requests the buffer does not follow the running time.
- R5: Alarm bytes (0x08..0x0E, same order as time) and the control byte (0x10: bit 0 binary/BCD select, bit 1 12/24-hour select) reach alarm_o and mode_o only when an alarm request (bit 2) commits. By default the bit then clears itself.
- R6: With STICKY_ALARM=1, bit 2 stays set after its commit until the host writes update-control with bit 2 equal to 0.
- R7: Each seconds tick advances the time. Seconds and minutes wrap after 59, hours after 23 and years after 99, each carrying into the next field. At a day rollover the one-hot weekday rotates left from bit 6 back to bit 0.
- R8: The day wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 29 for month 2 when year mod 4 is 0, 28 for month 2 otherwise, and 31 for all other months. The month wraps from 12 to 1.
- R9: If a time-write commit and a tick fall on the same edge, the loaded value wins and the tick is lost. If a time-read commit and a tick coincide, the snapshot holds the values from before the tick.
- R10: Writing 0 to a pending request bit neither cancels nor delays its transfer. Writes to unmapped addresses (0x07, 0x0F, 0x12..0x1F) have no effect, and those addresses read 0.
- R11: Update-control reads back as bit 0 time-write pending, bit 1 time-read pending, bit 2 alarm pending (or held), bit 4 delay select, and 0 in all other bits.
- R12: Requests that are pending together complete on one commit edge. With time-write and time-read together, the buffer keeps the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle pulse per second |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 5 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for addr_i (combinational) |
| time_o | output | 56 | Live counters, byte n = field n of the time order |
| alarm_o | output | 56 | Active alarm registers, same byte order |
| mode_o | output | 2 | Active control bits (binary/BCD, 12/24 h) |

## Verification
The case that matters is a seconds tick that lands on the same edge as a transfer commit. The commit edge follows the request write by a fixed and known number of cycles, so the bench raises the tick for exactly the cycle that ends on that edge. It does this once with a time-write request and once with a time-read request. For the write it expects the loaded value with no advance. For the read it expects the buffer to hold the pre-tick time while the live output shows one second more.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int NBYTES = 7;
  typedef logic [NBYTES-1:0][7:0] rtc_bytes_t;

  localparam int SEC_IDX  = 0;
  localparam int MIN_IDX  = 1;
  localparam int HOUR_IDX = 2;
  localparam int WDAY_IDX = 3;
  localparam int DATE_IDX = 4;
  localparam int MON_IDX  = 5;
  localparam int YEAR_IDX = 6;

  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h10;
  localparam logic [ADDR_W-1:0] UPD_ADDR  = 5'h11;

  localparam int UPD_WT   = 0;
  localparam int UPD_RT   = 1;
  localparam int UPD_AL   = 2;
  localparam int UPD_FAST = 4;

  localparam rtc_bytes_t RST_TIME = 56'h00_01_01_01_00_00_00;
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain import rtc_shadow_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  rtc_bytes_t load_val_i,
  output rtc_bytes_t cnt_o
);
  rtc_bytes_t cnt_q, cnt_d;
  logic [7:0] dim;
  logic c_sec, c_min, c_hour, c_day, c_mon;

  always_comb begin
    case (cnt_q[MON_IDX])
      8'd2:                     dim = (cnt_q[YEAR_IDX][1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: dim = 8'd30;
      default:                  dim = 8'd31;
    endcase
  end

  assign c_sec  = tick_i && (cnt_q[SEC_IDX]  >= 8'd59);
  assign c_min  = c_sec  && (cnt_q[MIN_IDX]  >= 8'd59);
  assign c_hour = c_min  && (cnt_q[HOUR_IDX] >= 8'd23);
  assign c_day  = c_hour && (cnt_q[DATE_IDX] >= dim);
  assign c_mon  = c_day  && (cnt_q[MON_IDX]  >= 8'd12);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      cnt_d[SEC_IDX] = c_sec ? 8'd0 : cnt_q[SEC_IDX] + 8'd1;
      if (c_sec)  cnt_d[MIN_IDX]  = c_min  ? 8'd0 : cnt_q[MIN_IDX] + 8'd1;
      if (c_min)  cnt_d[HOUR_IDX] = c_hour ? 8'd0 : cnt_q[HOUR_IDX] + 8'd1;
      if (c_hour) begin
        cnt_d[DATE_IDX] = c_day ? 8'd1 : cnt_q[DATE_IDX] + 8'd1;
        cnt_d[WDAY_IDX] = {1'b0, cnt_q[WDAY_IDX][5:0], cnt_q[WDAY_IDX][6]};
      end
      if (c_day)  cnt_d[MON_IDX]  = c_mon ? 8'd1 : cnt_q[MON_IDX] + 8'd1;
      if (c_mon)  cnt_d[YEAR_IDX] = (cnt_q[YEAR_IDX] >= 8'd99) ? 8'd0 : cnt_q[YEAR_IDX] + 8'd1;
    end
    // host load overrides a coincident tick
    if (load_i) cnt_d = load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RST_TIME;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r7_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q[SEC_IDX] == 8'd59) |=> cnt_q[SEC_IDX] == 8'd0);
  a_r9_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  a_r7_wday_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !cnt_q[WDAY_IDX][7]) |=>
      $countones(cnt_q[WDAY_IDX]) == $countones($past(cnt_q[WDAY_IDX])));
  a_r8_month_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_mon && !load_i) |=> cnt_q[MON_IDX] == 8'd1);
endmodule

// File: rtl/rtc_xfer_seq.sv
module rtc_xfer_seq #(
  parameter int unsigned CYC_PER_US   = 32,
  parameter int unsigned LONG_US      = 7320,
  parameter int unsigned SHORT_US     = 450,
  parameter bit          STICKY_ALARM = 1'b0
)(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] set_i,
  input  logic       clr_held_i,
  input  logic       fast_i,
  output logic [2:0] status_o,
  output logic [2:0] fire_o
);
  localparam int unsigned LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int unsigned SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int          CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);

  logic [2:0]       pend_q;
  logic             held_q, busy_q, sel_q, last;
  logic [CNT_W-1:0] cnt_q;

  assign last   = busy_q && (cnt_q == (sel_q ? SHORT_LAST : LONG_LAST));
  assign fire_o = last ? pend_q : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      held_q <= 1'b0;
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      // a request set on the commit edge stays for the next round
      pend_q <= (pend_q & ~fire_o) | set_i;
      held_q <= STICKY_ALARM ? ((held_q & ~clr_held_i) | fire_o[2]) : 1'b0;
      if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q + 1'b1;
      end else if (|pend_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        sel_q  <= fast_i;
      end
    end
  end

  assign status_o = {pend_q[2] | held_q, pend_q[1:0]};

  a_r3_clear_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o[0] && !set_i[0]) |=> !status_o[0]);
  a_r10_no_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !fire_o[0]) |=> status_o[0]);
  a_r3_drop_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[1]) |-> $past(fire_o[1]));

  if (STICKY_ALARM) begin : g_sticky
    a_r6_alarm_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o[2] |=> status_o[2]);
  end else begin : g_autoclr
    a_r5_alarm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o[2] && !set_i[2]) |=> !status_o[2]);
  end
endmodule

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl import rtc_shadow_pkg::*; #(
  parameter int unsigned CYC_PER_US   = 32,
  parameter int unsigned LONG_US      = 7320,
  parameter int unsigned SHORT_US     = 450,
  parameter bit          STICKY_ALARM = 1'b0
)(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sec_tick_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [55:0] time_o,
  output logic [55:0] alarm_o,
  output logic [1:0]  mode_o
);
  rtc_bytes_t live, time_buf_q, alrm_buf_q, alrm_act_q;
  logic [1:0] ctrl_buf_q, ctrl_act_q;
  logic       fast_q;
  logic [2:0] req_set, xfer_stat, fire;
  logic       clr_held, sel_time, sel_alrm, sel_ctrl, sel_upd;
  logic [2:0] byte_idx;

  assign byte_idx = addr_i[2:0];
  assign sel_time = (addr_i[4:3] == 2'b00) && (byte_idx != 3'd7);
  assign sel_alrm = (addr_i[4:3] == 2'b01) && (byte_idx != 3'd7);
  assign sel_ctrl = (addr_i == CTRL_ADDR);
  assign sel_upd  = (addr_i == UPD_ADDR);

  assign req_set  = (we_i && sel_upd) ? {wdata_i[UPD_AL], wdata_i[UPD_RT], wdata_i[UPD_WT]} : 3'b000;
  assign clr_held = we_i && sel_upd && !wdata_i[UPD_AL];

  rtc_xfer_seq #(
    .CYC_PER_US  (CYC_PER_US),
    .LONG_US     (LONG_US),
    .SHORT_US    (SHORT_US),
    .STICKY_ALARM(STICKY_ALARM)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (req_set),
    .clr_held_i(clr_held),
    .fast_i    (fast_q),
    .status_o  (xfer_stat),
    .fire_o    (fire)
  );

  rtc_time_chain u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sec_tick_i),
    .load_i    (fire[UPD_WT]),
    .load_val_i(time_buf_q),
    .cnt_o     (live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_buf_q <= '0;
    end else if (fire[UPD_RT] && !fire[UPD_WT]) begin
      time_buf_q <= live;
    end else if (we_i && sel_time) begin
      time_buf_q[byte_idx] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alrm_buf_q <= '0;
      ctrl_buf_q <= '0;
      fast_q     <= 1'b0;
    end else if (we_i) begin
      if (sel_alrm) alrm_buf_q[byte_idx] <= wdata_i;
      if (sel_ctrl) ctrl_buf_q <= wdata_i[1:0];
      if (sel_upd)  fast_q     <= wdata_i[UPD_FAST];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alrm_act_q <= '0;
      ctrl_act_q <= '0;
    end else if (fire[UPD_AL]) begin
      alrm_act_q <= alrm_buf_q;
      ctrl_act_q <= ctrl_buf_q;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (sel_time)      rdata_o = time_buf_q[byte_idx];
    else if (sel_alrm) rdata_o = alrm_buf_q[byte_idx];
    else if (sel_ctrl) rdata_o = {6'b0, ctrl_buf_q};
    else if (sel_upd)  rdata_o = {3'b000, fast_q, 1'b0, xfer_stat};
  end

  assign time_o  = live;
  assign alarm_o = alrm_act_q;
  assign mode_o  = ctrl_act_q;

  a_r2_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire[UPD_WT] && !sec_tick_i) |=> $stable(time_o));
  a_r4_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire[UPD_RT] && !fire[UPD_WT]) |=> time_buf_q == $past(live));
  a_r5_alarm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire[UPD_AL] |=> ($stable(alarm_o) && $stable(mode_o)));
  a_r12_joint_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire[UPD_WT] && fire[UPD_RT]) |=> time_buf_q == $past(time_buf_q));
endmodule

// File: tb/rtc_shadow_ctrl_test.sv
module rtc_shadow_ctrl_test;
  localparam int SHORT = 450;
  localparam int LONG  = 7320;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we_a = 1'b0, we_s = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0, rd_a, rd_s;
  logic [55:0] time_a, alarm_a, time_s, alarm_s;
  logic [1:0]  mode_a, mode_s;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_shadow_ctrl #(.CYC_PER_US(1), .LONG_US(LONG), .SHORT_US(SHORT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .we_i(we_a), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_a), .time_o(time_a), .alarm_o(alarm_a), .mode_o(mode_a));

  rtc_shadow_ctrl #(.CYC_PER_US(1), .LONG_US(LONG), .SHORT_US(SHORT), .STICKY_ALARM(1'b1)) uut_s (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .we_i(we_s), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_s), .time_o(time_s), .alarm_o(alarm_s), .mode_o(mode_s));

  typedef struct packed {
    logic [55:0] start;
    logic [7:0]  nt;
    logic [55:0] exp;
  } vec_t;

  // year_month_day_wday_hour_min_sec, binary
  localparam vec_t VEC [9] = '{
    '{56'h00_01_01_01_00_00_0A, 8'd1, 56'h00_01_01_01_00_00_0B},
    '{56'h00_01_01_01_00_05_3B, 8'd1, 56'h00_01_01_01_00_06_00},
    '{56'h63_0C_1F_40_17_3B_3B, 8'd1, 56'h00_01_01_01_00_00_00},
    '{56'h17_02_1C_04_17_3B_3B, 8'd1, 56'h17_03_01_08_00_00_00},
    '{56'h18_02_1C_04_17_3B_3B, 8'd1, 56'h18_02_1D_08_00_00_00},
    '{56'h18_02_1D_10_17_3B_3B, 8'd1, 56'h18_03_01_20_00_00_00},
    '{56'h05_04_1E_02_17_3B_3B, 8'd1, 56'h05_05_01_04_00_00_00},
    '{56'h05_07_0A_02_05_3B_3A, 8'd3, 56'h05_07_0A_02_06_00_01},
    '{56'h05_06_1E_20_17_3B_3B, 8'd1, 56'h05_07_01_40_00_00_00}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit s, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (s) we_s = 1'b1; else we_a = 1'b1;
    @(posedge clk);
    #1;
    we_a = 1'b0; we_s = 1'b0;
  endtask

  task automatic rd(input bit s, input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = s ? rd_s : rd_a;
  endtask

  task automatic wait_clear(input logic [7:0] mask);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(1'b0, 5'h11, v);
      if ((v & mask) == 8'h00) break;
      edges(1);
    end
  endtask

  task automatic put_buf(input logic [55:0] t);
    for (int i = 0; i < 7; i++) wr(1'b0, 5'(i), t[i*8 +: 8]);
  endtask

  task automatic get_buf(output logic [55:0] t);
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(1'b0, 5'(i), v);
      t[i*8 +: 8] = v;
    end
  endtask

  task automatic load_time(input logic [55:0] t);
    put_buf(t);
    wr(1'b0, 5'h11, 8'h11);
    wait_clear(8'h01);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
      #1;
      tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [55:0] t;
    edges(3);
    rst_n = 1'b1;
    edges(1);

    // R1 reset state
    check("R1 live time", time_a, 56'h00_01_01_01_00_00_00);
    rd(1'b0, 5'h11, v); check("R1 update reg", v, 8'h00);
    rd(1'b0, 5'h00, v); check("R1 time buffer", v, 8'h00);
    check("R1 alarm", alarm_a, 56'h0);
    check("R1 mode", mode_a, 2'b00);

    // R7 R8 counter chain vectors
    for (int k = 0; k < 9; k++) begin
      load_time(VEC[k].start);
      check("R2 load", time_a, VEC[k].start);
      ticks(int'(VEC[k].nt));
      check("R7 R8 chain", time_a, VEC[k].exp);
    end

    // R2 R3 long delay, exact commit edge
    put_buf(56'h11_02_03_04_05_06_07);
    check("R2 buffer write leaves live", time_a, VEC[8].exp);
    wr(1'b0, 5'h11, 8'h01);
    edges(LONG);
    rd(1'b0, 5'h11, v); check("R3 long still pending", v, 8'h01);
    check("R2 not yet loaded", time_a, VEC[8].exp);
    edges(1);
    rd(1'b0, 5'h11, v); check("R3 long cleared", v, 8'h00);
    check("R2 loaded", time_a, 56'h11_02_03_04_05_06_07);

    // R9 tick on a time-write commit edge (short delay)
    load_time(56'h00_01_01_01_0A_00_3B);
    put_buf(56'h00_01_01_01_0B_0B_0B);
    wr(1'b0, 5'h11, 8'h11);
    edges(SHORT);
    rd(1'b0, 5'h11, v); check("R3 short still pending", v, 8'h11);
    tick = 1'b1;
    edges(1);
    tick = 1'b0;
    rd(1'b0, 5'h11, v); check("R3 short cleared", v, 8'h10);
    check("R9 load beats tick", time_a, 56'h00_01_01_01_0B_0B_0B);

    // R9 tick on a time-read commit edge
    wr(1'b0, 5'h11, 8'h12);
    edges(SHORT);
    tick = 1'b1;
    edges(1);
    tick = 1'b0;
    get_buf(t); check("R9 snapshot pre-tick", t, 56'h00_01_01_01_0B_0B_0B);
    check("R9 live advanced", time_a, 56'h00_01_01_01_0B_0B_0C);

    // R4 read snapshot
    load_time(56'h0A_03_0F_04_08_1E_00);
    ticks(5);
    get_buf(t); check("R4 buffer not live", t, 56'h0A_03_0F_04_08_1E_00);
    wr(1'b0, 5'h11, 8'h12);
    wait_clear(8'h02);
    get_buf(t); check("R4 snapshot", t, 56'h0A_03_0F_04_08_1E_05);
    ticks(2);
    get_buf(t); check("R4 snapshot frozen", t, 56'h0A_03_0F_04_08_1E_05);
    check("R4 live running", time_a, 56'h0A_03_0F_04_08_1E_07);

    // R10 R11 writing zero does not cancel; unmapped addresses
    put_buf(56'h21_09_1E_08_0C_22_33);
    wr(1'b0, 5'h11, 8'h11);
    wr(1'b0, 5'h11, 8'h10);
    rd(1'b0, 5'h11, v); check("R10 R11 pending kept", v, 8'h11);
    wait_clear(8'h01);
    check("R10 transfer done", time_a, 56'h21_09_1E_08_0C_22_33);
    wr(1'b0, 5'h07, 8'hAA);
    wr(1'b0, 5'h1F, 8'h55);
    rd(1'b0, 5'h07, v); check("R10 unmapped 07", v, 8'h00);
    rd(1'b0, 5'h1F, v); check("R10 unmapped 1F", v, 8'h00);
    get_buf(t); check("R10 buffer intact", t, 56'h21_09_1E_08_0C_22_33);
    rd(1'b0, 5'h11, v); check("R11 fast bit only", v, 8'h10);

    // R12 joint write and read
    put_buf(56'h30_0B_02_01_03_04_05);
    wr(1'b0, 5'h11, 8'h13);
    wait_clear(8'h03);
    check("R12 live", time_a, 56'h30_0B_02_01_03_04_05);
    get_buf(t); check("R12 buffer kept", t, 56'h30_0B_02_01_03_04_05);

    // R5 alarm commit, auto-clear
    for (int i = 0; i < 7; i++) wr(1'b0, 5'(8 + i), 8'(8'h21 + i));
    wr(1'b0, 5'h10, 8'h03);
    check("R5 alarm before commit", alarm_a, 56'h0);
    check("R5 mode before commit", mode_a, 2'b00);
    rd(1'b0, 5'h08, v); check("R5 alarm buffer", v, 8'h21);
    wr(1'b0, 5'h11, 8'h14);
    wait_clear(8'h04);
    check("R5 alarm committed", alarm_a, 56'h27_26_25_24_23_22_21);
    check("R5 mode committed", mode_a, 2'b11);
    rd(1'b0, 5'h11, v); check("R5 alarm bit clear", v, 8'h10);

    // R6 sticky alarm variant
    for (int i = 0; i < 7; i++) wr(1'b1, 5'(8 + i), 8'(8'h41 + i));
    wr(1'b1, 5'h11, 8'h14);
    edges(SHORT + 1);
    check("R6 alarm committed", alarm_s, 56'h47_46_45_44_43_42_41);
    edges(3);
    rd(1'b1, 5'h11, v); check("R6 bit held", v, 8'h14);
    wr(1'b1, 5'h11, 8'h10);
    rd(1'b1, 5'h11, v); check("R6 bit cleared by host", v, 8'h10);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule